// File: doc/BRIEF.md
# Status Word with Banked Stack Pointers

This block keeps a 32-bit processor status word together with one live stack pointer and five banked copies of it. One copy belongs to the interrupt stack and four belong to the privilege execution levels. Bit 28 of the status word, the interrupt-stack bit, and bits 25:24, the execution level, choose which bank stands behind the live pointer. When a status write moves to a different bank, the block stores the live pointer into the bank it is leaving. It then loads the live pointer from the bank it is entering. Both steps happen in the clock of the write.

The four condition flags sit in the low nibble of the status word. The ALU updates them through their own port. A status read returns the stored upper 28 bits with the current flags merged into the low nibble. Debug logic can read and write each banked copy by index. Index 0 to 3 selects a level stack and index 4 selects the interrupt stack.

Top module: `psw_stack_bank`

## Requirements
- R1: After reset the status read port shows 0x10000000, with the interrupt stack selected and all flags clear. The live pointer and all five banks read zero.
- R2: The active bank is index 4 when status bit 28 is set. When bit 28 is clear, the active bank is the level in bits 25:24, which gives an index from 0 to 3.
- R3: A status write whose bit 28 differs from the stored bit 28 performs a stack swap.
- R4: When the stored bit 28 is clear, a status write that changes bits 25:24 performs a swap. When the stored bit 28 is set, a change to the level bits alone swaps nothing, and the live pointer and banks keep their values.
- R5: On a swap, the bank chosen by the old status receives the live pointer. The live pointer shows the prior content of the bank chosen by the new status from the next cycle on.
- R6: A status read returns bits 31:4 as last written. The low nibble holds carry in bit 3, overflow in bit 2, sign in bit 1 and zero in bit 0. A status write also loads the flags from its low nibble.
- R7: A flag update replaces only the low nibble and is visible on the next cycle. A status write in the same cycle takes priority over the flag update.
- R8: A live-pointer write lands on the next cycle. It is ignored in a cycle that performs a swap.
- R9: A debug bank write to index 0 to 4 lands on the next cycle and is ignored in a swap cycle. Indices 5 to 7 read as zero, and writes to them are dropped.
- R10: A status write that performs no swap leaves the live pointer and all banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| statusWrEn | input | 1 | Status write strobe |
| statusWrData | input | 32 | New status word |
| statusRdData | output | 32 | Status word with current flags merged |
| flagUpdEn | input | 1 | ALU flag update strobe |
| flagsIn | input | 4 | New flags {carry, overflow, sign, zero} |
| spWrEn | input | 1 | Live stack pointer write strobe |
| spWrData | input | 32 | Live stack pointer write value |
| spRdData | output | 32 | Live stack pointer |
| bankWrEn | input | 1 | Debug bank write strobe |
| bankSel | input | 3 | Debug bank index (0-3 levels, 4 interrupt) |
| bankWrData | input | 32 | Debug bank write value |
| bankRdData | output | 32 | Content of the bank at bankSel |

## Verification
Several internal faults show up one cycle after the faulty write. A wrong bank selection or a missed swap appears as a wrong live pointer value on that cycle. Saving into the wrong bank is different: the live pointer still looks right, so the fault stays hidden until that bank is read through the debug port or reloaded by a later swap. The bench therefore sweeps the debug read index every cycle. It also mixes swaps with direct pointer and bank writes, so that a lost save is read back within a few cycles of the swap that caused it.

// File: rtl/psw_stack_pkg.sv
package psw_stack_pkg;
  localparam int STATUS_W   = 32;
  localparam int FLAG_W     = 4;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int NUM_BANKS  = NUM_LEVELS + 1;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int INT_STACK_BIT = 28;
  localparam int LVL_LSB       = 24;
  localparam logic [STATUS_W-1:0] STATUS_RESET = 32'h1000_0000;

  typedef struct packed {
    logic                  swap;
    logic [BANK_IDX_W-1:0] saveIdx;
    logic [BANK_IDX_W-1:0] loadIdx;
    logic                  statusLoad;
    logic                  flagLoad;
    logic                  spLoad;
    logic                  bankLoad;
  } ctrl_strobes_t;

  function automatic logic [BANK_IDX_W-1:0] bankOf(input logic [STATUS_W-1:0] st);
    if (st[INT_STACK_BIT]) return BANK_IDX_W'(NUM_LEVELS);
    return BANK_IDX_W'(st[LVL_LSB +: LVL_W]);
  endfunction
endpackage

// File: rtl/psw_stack_ctrl.sv
module psw_stack_ctrl
  import psw_stack_pkg::*;
(
  input  logic                statusWrEn,
  input  logic [STATUS_W-1:0] statusWrData,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic                flagUpdEn,
  input  logic                spWrEn,
  input  logic                bankWrEn,
  output ctrl_strobes_t       strobes
);
  logic intChange;
  logic lvlChange;
  logic doSwap;

  always_comb begin
    intChange = curStatus[INT_STACK_BIT] != statusWrData[INT_STACK_BIT];
    lvlChange = !curStatus[INT_STACK_BIT] &&
                (curStatus[LVL_LSB +: LVL_W] != statusWrData[LVL_LSB +: LVL_W]);
    doSwap    = statusWrEn && (intChange || lvlChange);

    strobes.swap       = doSwap;
    strobes.saveIdx    = bankOf(curStatus);
    strobes.loadIdx    = bankOf(statusWrData);
    strobes.statusLoad = statusWrEn;
    strobes.flagLoad   = flagUpdEn && !statusWrEn;
    strobes.spLoad     = spWrEn && !doSwap;
    strobes.bankLoad   = bankWrEn && !doSwap;
  end
endmodule

// File: rtl/psw_stack_dp.sv
module psw_stack_dp
  import psw_stack_pkg::*;
#(
  parameter int SP_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         strobes,
  input  logic [STATUS_W-1:0]   statusWrData,
  input  logic [FLAG_W-1:0]     flagsIn,
  input  logic [SP_W-1:0]       spWrData,
  input  logic [BANK_IDX_W-1:0] bankSel,
  input  logic [SP_W-1:0]       bankWrData,
  output logic [STATUS_W-1:0]   curStatus,
  output logic [SP_W-1:0]       spRdData,
  output logic [SP_W-1:0]       bankRdData
);
  logic [STATUS_W-1:FLAG_W] statusHi;
  logic [FLAG_W-1:0]        flagsQ;
  logic [SP_W-1:0]          spQ;
  logic [SP_W-1:0]          bankQ [NUM_BANKS];
  logic [SP_W-1:0]          reloadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusHi <= STATUS_RESET[STATUS_W-1:FLAG_W];
      flagsQ   <= STATUS_RESET[FLAG_W-1:0];
    end else if (strobes.statusLoad) begin
      statusHi <= statusWrData[STATUS_W-1:FLAG_W];
      flagsQ   <= statusWrData[FLAG_W-1:0];
    end else if (strobes.flagLoad) begin
      flagsQ   <= flagsIn;
    end
  end

  always_comb begin
    reloadVal = '0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (strobes.loadIdx == BANK_IDX_W'(k)) reloadVal = bankQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              spQ <= '0;
    else if (strobes.swap)  spQ <= reloadVal;
    else if (strobes.spLoad) spQ <= spWrData;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)
        bankQ[b] <= '0;
      else if (strobes.swap && strobes.saveIdx == BANK_IDX_W'(b))
        bankQ[b] <= spQ;
      else if (strobes.bankLoad && bankSel == BANK_IDX_W'(b))
        bankQ[b] <= bankWrData;
    end
  end

  always_comb begin
    bankRdData = '0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (bankSel == BANK_IDX_W'(k)) bankRdData = bankQ[k];
  end

  assign curStatus = {statusHi, flagsQ};
  assign spRdData  = spQ;
endmodule

// File: rtl/psw_stack_bank.sv
module psw_stack_bank
  import psw_stack_pkg::*;
#(
  parameter int SP_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  statusWrEn,
  input  logic [STATUS_W-1:0]   statusWrData,
  output logic [STATUS_W-1:0]   statusRdData,
  input  logic                  flagUpdEn,
  input  logic [FLAG_W-1:0]     flagsIn,
  input  logic                  spWrEn,
  input  logic [SP_W-1:0]       spWrData,
  output logic [SP_W-1:0]       spRdData,
  input  logic                  bankWrEn,
  input  logic [BANK_IDX_W-1:0] bankSel,
  input  logic [SP_W-1:0]       bankWrData,
  output logic [SP_W-1:0]       bankRdData
);
  ctrl_strobes_t       strobes;
  logic [STATUS_W-1:0] curStatus;

  psw_stack_ctrl ctrl_i (
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .curStatus    (curStatus),
    .flagUpdEn    (flagUpdEn),
    .spWrEn       (spWrEn),
    .bankWrEn     (bankWrEn),
    .strobes      (strobes)
  );

  psw_stack_dp #(.SP_W(SP_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .statusWrData (statusWrData),
    .flagsIn      (flagsIn),
    .spWrData     (spWrData),
    .bankSel      (bankSel),
    .bankWrData   (bankWrData),
    .curStatus    (curStatus),
    .spRdData     (spRdData),
    .bankRdData   (bankRdData)
  );

  assign statusRdData = curStatus;
endmodule

// File: rtl/psw_stack_bank_chk.sv
module psw_stack_bank_chk
  import psw_stack_pkg::*;
#(
  parameter int SP_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                statusWrEn,
  input logic [STATUS_W-1:0] statusWrData,
  input logic [STATUS_W-1:0] statusRdData,
  input logic                flagUpdEn,
  input logic [FLAG_W-1:0]   flagsIn,
  input logic                spWrEn,
  input logic [SP_W-1:0]     spWrData,
  input logic [SP_W-1:0]     spRdData,
  input logic                swapStrobe
);
  // R6: upper status bits follow a write on the next cycle
  assert_status_hi_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |=> statusRdData[STATUS_W-1:FLAG_W] == $past(statusWrData[STATUS_W-1:FLAG_W]));

  // R7: a lone flag update touches only the low nibble
  assert_flag_update_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagUpdEn && !statusWrEn) |=> (statusRdData[FLAG_W-1:0] == $past(flagsIn)) &&
      $stable(statusRdData[STATUS_W-1:FLAG_W]));

  // R4: level change on the interrupt stack keeps the live pointer
  assert_no_swap_on_int_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrEn && !spWrEn && statusRdData[INT_STACK_BIT] && statusWrData[INT_STACK_BIT])
      |=> $stable(spRdData));

  // R8: a pointer write with no status write lands next cycle
  assert_sp_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (spWrEn && !statusWrEn) |=> spRdData == $past(spWrData));

  // R3: a swap only ever comes from a status write
  assert_swap_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    swapStrobe |-> statusWrEn);

  // R10: quiet cycles keep the live pointer
  assert_idle_sp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWrEn && !spWrEn) |=> $stable(spRdData));
endmodule

bind psw_stack_bank psw_stack_bank_chk #(.SP_W(SP_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .statusWrEn   (statusWrEn),
  .statusWrData (statusWrData),
  .statusRdData (statusRdData),
  .flagUpdEn    (flagUpdEn),
  .flagsIn      (flagsIn),
  .spWrEn       (spWrEn),
  .spWrData     (spWrData),
  .spRdData     (spRdData),
  .swapStrobe   (strobes.swap)
);

// File: tb/psw_stack_bank_tb.sv
module psw_stack_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic [31:0] statusRdData;
  logic        flagUpdEn = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic        spWrEn = 1'b0;
  logic [31:0] spWrData = '0;
  logic [31:0] spRdData;
  logic        bankWrEn = 1'b0;
  logic [2:0]  bankSel = '0;
  logic [31:0] bankWrData = '0;
  logic [31:0] bankRdData;

  int vectors = 0;
  int fails = 0;

  logic [31:0] mStatus;
  logic [31:0] mSp;
  logic [31:0] mBank [5];

  always #5 clk = ~clk;

  psw_stack_bank dut_i (
    .clk(clk), .rstN(rstN),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .statusRdData(statusRdData),
    .flagUpdEn(flagUpdEn), .flagsIn(flagsIn),
    .spWrEn(spWrEn), .spWrData(spWrData), .spRdData(spRdData),
    .bankWrEn(bankWrEn), .bankSel(bankSel), .bankWrData(bankWrData), .bankRdData(bankRdData)
  );

  function automatic int selOf(input logic [31:0] st);
    return st[28] ? 4 : int'(st[25:24]);
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, advance the model, then compare all outputs.
  task automatic step(input string tag, input logic sw, input logic [31:0] swd,
                      input logic fu, input logic [3:0] fi,
                      input logic spw, input logic [31:0] spd,
                      input logic bw, input logic [2:0] bs, input logic [31:0] bd);
    logic swap;
    logic [31:0] reload;
    statusWrEn = sw; statusWrData = swd; flagUpdEn = fu; flagsIn = fi;
    spWrEn = spw; spWrData = spd; bankWrEn = bw; bankSel = bs; bankWrData = bd;
    swap = sw && ((mStatus[28] != swd[28]) || (!mStatus[28] && mStatus[25:24] != swd[25:24]));
    if (swap) begin
      reload = mBank[selOf(swd)];
      mBank[selOf(mStatus)] = mSp;
      mSp = reload;
    end else begin
      if (spw) mSp = spd;
      if (bw && bs < 3'd5) mBank[bs] = bd;
    end
    if (sw) mStatus = swd;
    else if (fu) mStatus[3:0] = fi;
    @(negedge clk);
    check(tag, "status", statusRdData, mStatus);
    check(tag, "sp", spRdData, mSp);
    check(tag, "bank", bankRdData, (bs < 3'd5) ? mBank[bs] : 32'h0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mStatus = 32'h1000_0000; mSp = '0;
    for (int i = 0; i < 5; i++) mBank[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values, sweep every bank
    check("R1", "status", statusRdData, 32'h1000_0000);
    for (int i = 0; i < 5; i++) step("R1", 0, 0, 0, 0, 0, 0, 0, 3'(i), 0);
    // R8: direct pointer write
    step("R8", 0, 0, 0, 0, 1, 32'h0000_1111, 0, 0, 0);
    // R4: level change on interrupt stack, no swap
    step("R4", 1, 32'h1200_0000, 0, 0, 0, 0, 0, 4, 0);
    // R9: debug bank writes
    step("R9", 0, 0, 0, 0, 0, 0, 1, 2, 32'h0000_AAAA);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_00B0);
    // R3 R2 R5: leave interrupt stack for level 2
    step("R3", 1, 32'h0200_0000, 0, 0, 0, 0, 0, 4, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 2, 0);
    // R4 R8 R9: level change with interrupt bit clear, pointer and bank writes ignored
    step("R4", 1, 32'h0000_0005, 0, 0, 1, 32'h0000_DEAD, 1, 0, 32'h0000_BEEF);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 2, 0);
    // R7: flag update alone, then collision with a status write
    step("R7", 0, 0, 1, 4'hA, 0, 0, 0, 0, 0);
    step("R7", 1, 32'h0000_0003, 1, 4'hC, 0, 0, 0, 0, 0);
    // R10 R6: non-swapping write changes upper bits and flags only
    step("R10", 1, 32'h00F0_ABC9, 0, 0, 0, 0, 0, 1, 0);
    // R9: out-of-range index reads zero and drops writes
    step("R9", 0, 0, 0, 0, 0, 0, 1, 7, 32'h5555_5555);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 3, 0);
    // R6: random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R6", r[0] & r[1], $urandom & 32'hF3F0_FFFF | ($urandom & 32'h0300_000F),
           r[2], r[7:4], r[8] & r[9], $urandom, r[10] & r[11], 3'(r[14:12] % 6), $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule